// File: doc/BRIEF.md
# Flash Burst-Configuration Command Decoder

This block sits on the write side of a flash-style command interface. It watches each bus write (a one-cycle write strobe with a 20-bit address and a data byte) and picks out the three-write sequence that programs the burst configuration register. The first two writes are unlock cycles. The third write is a confirm cycle. On that cycle the eight high address bits carry the new configuration code. The data byte does not carry it.

The stored code is split into three fields: a synchronous-mode enable, a wait-state count (clocks from the address-valid strobe to first data) and four further burst parameter bits. A busy input marks a program, erase or sector-lock operation in progress. While it is high, a confirm cycle does not change the register.

Any write that breaks the expected order sends the decoder into a lockout state and raises an error flag. Only the reset command (data F0h at any address) clears the lockout. The reset command leaves the configuration register unchanged.

Top module: `burstcfg_decoder`

## Requirements
- R1: After `rst_n` is deasserted, `cfg_sync_en`=0 (asynchronous mode), `cfg_wait`=0, `cfg_param`=0, `seq_error`=0 and `cfg_update`=0.
- R2: The three writes data AAh at address 555h, then 55h at 2AAh, then C0h at 555h load the code `wr_addr[19:12]` of the third write into the register. The fields take these values: `cfg_wait`=`wr_addr[14:12]`, `cfg_param`=`wr_addr[18:15]` and `cfg_sync_en`=NOT `wr_addr[19]`. The outputs change at the clock edge that samples the third write, so they are visible in the following cycle.
- R3: Addresses are matched on `wr_addr[11:0]` only. Bits 19:12 of the two unlock writes have no effect on recognition.
- R4: A load with `wr_addr[19]`=1 selects asynchronous mode (`cfg_sync_en`=0). A load with `wr_addr[19]`=0 selects synchronous mode.
- R5: If `busy` is high during the confirm write, the register keeps its value and no update pulse occurs. The sequence returns to idle without an error.
- R6: A write with the wrong data or wrong low address at any of the three steps sets `seq_error` from the next cycle on. The register is unchanged.
- R7: While `seq_error` is set, every write other than data F0h is ignored, including a complete valid sequence. The register and the error flag hold.
- R8: A write of data F0h at any address clears `seq_error` and the sequence state from the next cycle. The register is unchanged.
- R9: An F0h write in the middle of a sequence abandons that sequence. Cycles with `wr_en` low never advance or break the sequence.
- R10: `cfg_update` is high for exactly one cycle: the cycle after a confirm write that loaded the register. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Program, erase or lock operation in progress |
| cfg_sync_en | output | 1 | Synchronous burst mode enabled |
| cfg_wait | output | 3 | Programmed wait-state count |
| cfg_param | output | 4 | Other burst parameter bits |
| cfg_update | output | 1 | One-cycle pulse when the register was loaded |
| seq_error | output | 1 | Lockout after an invalid sequence |

## Verification
The bench sends unlock addresses with their high bits set. A decoder that compared all 20 bits would reject these writes and raise the error flag. It places idle cycles between the steps of a sequence. A decoder that counted cycles instead of writes would lose its place. A confirm write under `busy` checks that the register neither changes nor pulses, and that no spurious error appears. The bench also sends a complete valid sequence while in lockout. A design that did not hold the lockout would load the register. The bench then checks that the F0h recovery keeps the previously loaded code and does not restore the reset default.

// File: rtl/burstcfg_pkg.sv
package burstcfg_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_GOT_ONE = 2'd1,
      SEQ_GOT_TWO = 2'd2,
      SEQ_LOCKOUT = 2'd3
   } seq_state_e;

   // indices into the matcher hit vector
   localparam int HIT_UNLOCK_A = 0;
   localparam int HIT_UNLOCK_B = 1;
   localparam int HIT_CONFIRM  = 2;
   localparam int HIT_CLEAR    = 3;
   localparam int NUM_HITS     = 4;

endpackage

// File: rtl/burstcfg_cmd_match.sv
module burstcfg_cmd_match #(
   parameter int          CMP_W      = 12,
   parameter int          DATA_W     = 8,
   parameter logic [11:0] MATCH_ADDR = 12'h555,
   parameter logic [7:0]  MATCH_DATA = 8'hAA,
   parameter bit          ANY_ADDR   = 1'b0
) (
   input  logic [CMP_W-1:0]  low_addr,
   input  logic [DATA_W-1:0] data,
   output logic              hit
);

   localparam logic [CMP_W-1:0]  ADDR_KEY = CMP_W'(MATCH_ADDR);
   localparam logic [DATA_W-1:0] DATA_KEY = DATA_W'(MATCH_DATA);

   generate
      if (ANY_ADDR) begin : g_data_only
         assign hit = (data == DATA_KEY);
         logic unused_addr;
         assign unused_addr = ^low_addr;
      end else begin : g_addr_data
         assign hit = (data == DATA_KEY) && (low_addr == ADDR_KEY);
      end
   endgenerate

endmodule

// File: rtl/burstcfg_seq_fsm.sv
module burstcfg_seq_fsm
   import burstcfg_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                busy,
   input  logic [NUM_HITS-1:0] hit,
   output logic                load_req,
   output logic                locked_out
);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      load_req = 1'b0;
      if (wr_en) begin
         if (hit[HIT_CLEAR]) begin
            state_d = SEQ_IDLE;
         end else begin
            unique case (state_q)
               SEQ_IDLE:    state_d = hit[HIT_UNLOCK_A] ? SEQ_GOT_ONE : SEQ_LOCKOUT;
               SEQ_GOT_ONE: state_d = hit[HIT_UNLOCK_B] ? SEQ_GOT_TWO : SEQ_LOCKOUT;
               SEQ_GOT_TWO: begin
                  if (hit[HIT_CONFIRM]) begin
                     state_d  = SEQ_IDLE;
                     load_req = !busy;
                  end else begin
                     state_d = SEQ_LOCKOUT;
                  end
               end
               default:     state_d = SEQ_LOCKOUT;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign locked_out = (state_q == SEQ_LOCKOUT);

endmodule

// File: rtl/burstcfg_store.sv
module burstcfg_store #(
   parameter int   CODE_W       = 8,
   parameter int   WAIT_W       = 3,
   parameter logic [7:0] DEFAULT_CODE = 8'h80,
   parameter bit   SYNC_ON_ZERO = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [CODE_W-1:0]           code_in,
   output logic                        sync_en,
   output logic [WAIT_W-1:0]           wait_cnt,
   output logic [CODE_W-WAIT_W-2:0]    param,
   output logic                        update
);

   localparam int MODE_BIT = CODE_W - 1;
   localparam int PARAM_W  = CODE_W - WAIT_W - 1;
   localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(DEFAULT_CODE);

   logic [CODE_W-1:0] code_q;
   logic              update_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= RST_CODE;
         update_q <= 1'b0;
      end else begin
         update_q <= load;
         if (load) code_q <= code_in;
      end
   end

   generate
      if (SYNC_ON_ZERO) begin : g_sync_low
         assign sync_en = ~code_q[MODE_BIT];
      end else begin : g_sync_high
         assign sync_en = code_q[MODE_BIT];
      end
   endgenerate

   assign wait_cnt = code_q[WAIT_W-1:0];
   assign param    = code_q[WAIT_W +: PARAM_W];
   assign update   = update_q;

endmodule

// File: rtl/burstcfg_decoder.sv
module burstcfg_decoder
   import burstcfg_pkg::*;
#(
   parameter int          ADDR_W       = 20,
   parameter int          DATA_W       = 8,
   parameter int          CMP_W        = 12,
   parameter int          WAIT_W       = 3,
   parameter logic [11:0] UNLOCK_A_ADR = 12'h555,
   parameter logic [7:0]  UNLOCK_A_DAT = 8'hAA,
   parameter logic [11:0] UNLOCK_B_ADR = 12'h2AA,
   parameter logic [7:0]  UNLOCK_B_DAT = 8'h55,
   parameter logic [7:0]  CONFIRM_DAT  = 8'hC0,
   parameter logic [7:0]  CLEAR_DAT    = 8'hF0,
   parameter logic [7:0]  DEFAULT_CODE = 8'h80,
   parameter bit          SYNC_ON_ZERO = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          busy,
   output logic                          cfg_sync_en,
   output logic [WAIT_W-1:0]             cfg_wait,
   output logic [ADDR_W-CMP_W-WAIT_W-2:0] cfg_param,
   output logic                          cfg_update,
   output logic                          seq_error
);

   localparam int CODE_W = ADDR_W - CMP_W;

   localparam logic [11:0] STEP_ADR [NUM_HITS] = '{UNLOCK_A_ADR, UNLOCK_B_ADR, UNLOCK_A_ADR, 12'h000};
   localparam logic [7:0]  STEP_DAT [NUM_HITS] = '{UNLOCK_A_DAT, UNLOCK_B_DAT, CONFIRM_DAT, CLEAR_DAT};
   localparam bit          STEP_ANY [NUM_HITS] = '{1'b0, 1'b0, 1'b0, 1'b1};

   generate
      if (CMP_W < 1 || CMP_W > 12) begin : g_bad_cmp
         $error("CMP_W must lie in 1..12");
      end
      if (CODE_W < WAIT_W + 2) begin : g_bad_code
         $error("address above CMP_W too narrow for mode, wait and parameter fields");
      end
      if (DATA_W < 1 || DATA_W > 8) begin : g_bad_data
         $error("DATA_W must lie in 1..8");
      end
      if (DEFAULT_CODE[CODE_W-1] != SYNC_ON_ZERO) begin : g_bad_default
         $error("DEFAULT_CODE must select asynchronous mode");
      end
   endgenerate

   logic [NUM_HITS-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_HITS; i++) begin : g_match
         burstcfg_cmd_match #(
            .CMP_W      (CMP_W),
            .DATA_W     (DATA_W),
            .MATCH_ADDR (STEP_ADR[i]),
            .MATCH_DATA (STEP_DAT[i]),
            .ANY_ADDR   (STEP_ANY[i])
         ) u_match (
            .low_addr (wr_addr[CMP_W-1:0]),
            .data     (wr_data),
            .hit      (hit[i])
         );
      end
   endgenerate

   logic load_req;

   burstcfg_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .busy       (busy),
      .hit        (hit),
      .load_req   (load_req),
      .locked_out (seq_error)
   );

   burstcfg_store #(
      .CODE_W       (CODE_W),
      .WAIT_W       (WAIT_W),
      .DEFAULT_CODE (DEFAULT_CODE),
      .SYNC_ON_ZERO (SYNC_ON_ZERO)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_req),
      .code_in  (wr_addr[ADDR_W-1:CMP_W]),
      .sync_en  (cfg_sync_en),
      .wait_cnt (cfg_wait),
      .param    (cfg_param),
      .update   (cfg_update)
   );

endmodule

// File: rtl/burstcfg_checker.sv
module burstcfg_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [19:0] wr_addr,
   input logic [7:0]  wr_data,
   input logic        busy,
   input logic        cfg_sync_en,
   input logic [2:0]  cfg_wait,
   input logic [3:0]  cfg_param,
   input logic        cfg_update,
   input logic        seq_error
);

   logic [7:0] cfg_view;
   assign cfg_view = {cfg_sync_en, cfg_param, cfg_wait};

   assert_reset_async_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!cfg_sync_en && !seq_error && !cfg_update));

   assert_change_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_view) |-> cfg_update);

   assert_mode_from_a19_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && wr_data == 8'hC0) |=> (cfg_update -> (cfg_sync_en == !$past(wr_addr[19]))));

   assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> !cfg_update);

   assert_lockout_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_error && !(wr_en && wr_data == 8'hF0)) |=> (seq_error && !cfg_update));

   assert_clear_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == 8'hF0) |=> (!seq_error && !cfg_update));

   assert_idle_no_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(seq_error) && !cfg_update));

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_update |=> !cfg_update);

endmodule

bind burstcfg_decoder burstcfg_checker u_chk (.*);

// File: tb/sim_burstcfg_decoder.sv
module sim_burstcfg_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        busy = 1'b0;
   logic        cfg_sync_en;
   logic [2:0]  cfg_wait;
   logic [3:0]  cfg_param;
   logic        cfg_update;
   logic        seq_error;

   always #4 clk = ~clk;   // 125 MHz

   burstcfg_decoder u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .cfg_sync_en(cfg_sync_en),
      .cfg_wait(cfg_wait), .cfg_param(cfg_param), .cfg_update(cfg_update),
      .seq_error(seq_error)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // expected item: {sync, param[3:0], wait[2:0], update, error}
   logic [9:0] exp_q [$];
   string      tag_q [$];

   // behavioural model built from the requirements
   int         m_st   = 0;      // 0 idle, 1 one unlock, 2 two unlocks, 3 lockout
   logic [7:0] m_code = 8'h80;

   task automatic cyc(input bit we, input logic [19:0] a, input logic [7:0] d,
                      input bit bz, input string tag);
      bit upd;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; busy = bz;
      upd = 1'b0;
      if (we) begin
         if (d == 8'hF0) m_st = 0;
         else case (m_st)
            0: m_st = (d == 8'hAA && a[11:0] == 12'h555) ? 1 : 3;
            1: m_st = (d == 8'h55 && a[11:0] == 12'h2AA) ? 2 : 3;
            2: if (d == 8'hC0 && a[11:0] == 12'h555) begin
                  m_st = 0;
                  if (!bz) begin m_code = a[19:12]; upd = 1'b1; end
               end else m_st = 3;
            default: m_st = 3;
         endcase
      end
      exp_q.push_back({~m_code[7], m_code[6:3], m_code[2:0], upd, (m_st == 3)});
      tag_q.push_back(tag);
   endtask

   task automatic load_seq(input logic [7:0] code, input bit bz, input string tag);
      cyc(1, 20'h00555, 8'hAA, 0, tag);
      cyc(1, 20'h002AA, 8'h55, 0, tag);
      cyc(1, {code, 12'h555}, 8'hC0, bz, tag);
   endtask

   // monitor: compare two ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [9:0] e;
         logic [9:0] act;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         act = {cfg_sync_en, cfg_param, cfg_wait, cfg_update, seq_error};
         n_vec++;
         if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual sync=%b param=%h wait=%0d upd=%b err=%b expected sync=%b param=%h wait=%0d upd=%b err=%b",
                     t, act[9], act[8:5], act[4:2], act[1], act[0],
                     e[9], e[8:5], e[4:2], e[1], e[0]);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, "R1 reset state");
      cyc(0, 0, 0, 0, "R1 reset state");
      // R2: synchronous load, wait 6, param 5
      load_seq(8'b0_0101_110, 0, "R2 load");
      cyc(0, 0, 0, 0, "R10 pulse ends");
      // R3/R4: unlock addresses carry high bits; async code
      cyc(1, 20'hFF555, 8'hAA, 0, "R3 high bits");
      cyc(1, 20'hA52AA, 8'h55, 0, "R3 high bits");
      cyc(1, {8'b1_0011_011, 12'h555}, 8'hC0, 0, "R4 async");
      // R9: idle cycles between steps, then sync load
      cyc(1, 20'h00555, 8'hAA, 0, "R9 gaps");
      cyc(0, 20'h00555, 8'h13, 0, "R9 gaps");
      cyc(1, 20'h002AA, 8'h55, 0, "R9 gaps");
      cyc(0, 20'h00000, 8'hAA, 0, "R9 gaps");
      cyc(1, {8'b0_1111_001, 12'h555}, 8'hC0, 0, "R9 gaps");
      // R5: busy confirm blocked, no error, next sequence works
      load_seq(8'b0_0000_111, 1, "R5 busy");
      cyc(0, 0, 0, 0, "R5 busy");
      load_seq(8'b0_0010_100, 0, "R5 after busy");
      // R6: wrong data in step two
      cyc(1, 20'h00555, 8'hAA, 0, "R6 bad data");
      cyc(1, 20'h002AA, 8'h56, 0, "R6 bad data");
      // R7: valid sequence ignored in lockout
      load_seq(8'b1_1110_010, 0, "R7 lockout");
      cyc(1, 20'h00555, 8'h00, 0, "R7 lockout");
      // R8: clear at arbitrary address, register kept
      cyc(1, 20'h7B3C1, 8'hF0, 0, "R8 clear");
      cyc(0, 0, 0, 0, "R8 clear");
      // R6: wrong low address in confirm step
      cyc(1, 20'h00555, 8'hAA, 0, "R6 bad addr");
      cyc(1, 20'h002AA, 8'h55, 0, "R6 bad addr");
      cyc(1, 20'h33554, 8'hC0, 0, "R6 bad addr");
      cyc(1, 20'h00000, 8'hF0, 0, "R8 clear");
      // R6: wrong first write
      cyc(1, 20'h002AA, 8'hAA, 0, "R6 bad first");
      cyc(1, 20'h00555, 8'hF0, 0, "R8 clear");
      // R9: clear mid-sequence, stray confirm, then recovery
      cyc(1, 20'h00555, 8'hAA, 0, "R9 abort");
      cyc(1, 20'h002AA, 8'h55, 0, "R9 abort");
      cyc(1, 20'h12345, 8'hF0, 0, "R9 abort");
      cyc(1, {8'h00, 12'h555}, 8'hC0, 0, "R9 stray confirm");
      cyc(1, 20'h00000, 8'hF0, 0, "R8 clear");
      load_seq(8'b1_0101_101, 0, "R2 final load");
      cyc(0, 0, 0, 0, "R10 pulse ends");
      cyc(0, 0, 0, 0, "R10 idle");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual run still active expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule